// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Threshold Flags

This block is a first-in first-out buffer of 9-bit words. It has one clock for writing and one for reading. The two clocks may be fully independent or driven from a single source. Four active-low status outputs report how full the buffer is. The empty and full flags mark the two ends of the buffer. The almost-empty and almost-full flags trip at thresholds held in two offset registers. Both offsets come back to 7 at every reset and can be reloaded at run time.

The write and read pointers carry one extra wrap bit. Each pointer crosses into the other clock domain as Gray code through a two-flop synchronizer. A flag is set by its own domain's pointer in the same edge that moves it, so assertion is prompt. Deassertion waits for the far pointer to come through the synchronizer. The empty and full flags are the back-pressure: an enable presented while the matching flag is low is dropped.

The level of `wen2_ld` while reset is low selects one of two modes. In dual-enable mode that pin is a second write enable. In load mode it is a load strobe: holding it low redirects the write and read enables to the offset registers.

Top module: `thr_fifo`

## Requirements
- R1: While `rst_n` is low, `full_n` and `afull_n` are 1, `empty_n` and `aempty_n` are 0, and `dout` is 0.
- R2: When `wen2_ld` is high during reset, the block is in dual-enable mode. A word is written only with `wen1_n`=0 and `wen2_ld`=1. With `wen2_ld`=0 nothing is stored.
- R3: When `wen2_ld` is low during reset, the block is in load mode. With `wen2_ld` high, `wen1_n`=0 alone writes `din`.
- R4: A word is popped into `dout` on a rising `rclk` edge only when `ren1_n` and `ren2_n` are both 0. Otherwise `dout` keeps its previous word.
- R5: Words leave in the order they were written, with no loss or duplication.
- R6: With no reads after reset, `full_n` falls after exactly DEPTH writes. Writes offered while `full_n` is 0 are dropped.
- R7: Reads offered while `empty_n` is 0 are dropped, and `dout` holds its value.
- R8: `aempty_n` is 0 exactly when the stored count is at most the empty offset n. `afull_n` is 0 exactly when the count is at least DEPTH−m, where m is the full offset. Both offsets are 7 after reset.
- R9: In load mode with `wen2_ld`=0, each `rclk`-independent `wclk` edge with `wen1_n`=0 loads `din` into an offset register. The registers are loaded in turn: empty offset first after reset, then full offset, and so on. The FIFO contents do not change.
- R10: In load mode with `wen2_ld`=0, each `rclk` edge with both read enables 0 places the next offset on `dout`, zero-extended. The order is empty offset first after reset, then full offset, alternating. No word is popped.
- R11: Once traffic stops, all four flags match the stored count within six cycles of their clocks. The write pointer's Gray code changes by at most one bit per `wclk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; also the window in which the mode is sampled |
| wclk | input | 1 | Write clock |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable (dual-enable mode) or active-low offset load strobe (load mode) |
| din | input | DW | Write data, also the offset value when loading |
| full_n | output | 1 | Active-low full flag, `wclk` domain |
| afull_n | output | 1 | Active-low almost-full flag, `wclk` domain |
| rclk | input | 1 | Read clock |
| ren1_n | input | 1 | Active-low read enable one |
| ren2_n | input | 1 | Active-low read enable two |
| dout | output | DW | Registered read data or offset readback |
| empty_n | output | 1 | Active-low empty flag, `rclk` domain |
| aempty_n | output | 1 | Active-low almost-empty flag, `rclk` domain |

## Verification
The bench first drives directed fills and drains in dual-enable mode:
- It stops at the default thresholds (7/8 words and DEPTH−8/DEPTH−7 words), which separates an off-by-one compare from a correct one.
- It runs past DEPTH, which tells a dropped write apart from an overwrite.
- It keeps reading after empty, which tells a held output apart from a stray pop.

Writes with only the second enable wrong show whether the mode gate is active. A seeded random phase then mixes simultaneous reads and writes, to expose pointer or synchronizer errors that ordered traffic hides. Load mode is tried with non-default offsets (3 and 10) and their readback. Interleaving readbacks with data pops shows that offset access never disturbs the queue.

// File: rtl/thf_pkg.sv
package thf_pkg;
  typedef enum logic {
    MODE_TWO_EN = 1'b0,
    MODE_LOAD   = 1'b1
  } thf_mode_e;
endpackage

// File: rtl/thf_sync2.sv
module thf_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/thf_wr_ctrl.sv
module thf_wr_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] full_off,
  output logic          we,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n
);
  localparam logic [AW:0] CAP = {1'b1, {AW{1'b0}}};

  logic [AW:0] bin_nx, gray_nx, rbin_s, cnt_nx;

  always_comb begin
    we      = wr_req & full_n;
    bin_nx  = wbin + {{AW{1'b0}}, we};
    gray_nx = (bin_nx >> 1) ^ bin_nx;
    rbin_s[AW] = rgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    cnt_nx  = bin_nx - rbin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin    <= bin_nx;
      wgray   <= gray_nx;
      full_n  <= (gray_nx != {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
      afull_n <= (cnt_nx < (CAP - {1'b0, full_off}));
    end
  end
endmodule

// File: rtl/thf_rd_ctrl.sv
module thf_rd_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] empty_off,
  output logic          re,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [AW:0] bin_nx, gray_nx, wbin_s, cnt_nx;

  always_comb begin
    re      = rd_req & empty_n;
    bin_nx  = rbin + {{AW{1'b0}}, re};
    gray_nx = (bin_nx >> 1) ^ bin_nx;
    wbin_s[AW] = wgray_s[AW];
    for (int i = AW - 1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    cnt_nx  = wbin_s - bin_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= bin_nx;
      rgray    <= gray_nx;
      empty_n  <= (gray_nx != wgray_s);
      aempty_n <= (cnt_nx > {1'b0, empty_off});
    end
  end
endmodule

// File: rtl/thf_offsets.sv
module thf_offsets #(
  parameter int DW      = 9,
  parameter int AW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          off_wr,
  input  logic [DW-1:0] din,
  input  logic          rclk,
  input  logic          off_rd,
  output logic [AW-1:0] empty_off,
  output logic [AW-1:0] full_off,
  output logic [DW-1:0] rd_word
);
  localparam logic [AW-1:0] DEF_V = AW'(DEF_OFF);

  logic wsel, rsel;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      empty_off <= DEF_V;
      full_off  <= DEF_V;
      wsel      <= 1'b0;
    end else if (off_wr) begin
      if (wsel) full_off <= AW'(din);
      else      empty_off <= AW'(din);
      wsel <= ~wsel;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      rsel <= 1'b0;
    else if (off_rd) rsel <= ~rsel;
  end

  assign rd_word = rsel ? DW'(full_off) : DW'(empty_off);
endmodule

// File: rtl/thr_fifo.sv
module thr_fifo
  import thf_pkg::*;
#(
  parameter int DW      = 9,
  parameter int DEPTH   = 512,
  parameter int DEF_OFF = 7
) (
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          ren1_n,
  input  logic          ren2_n,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);

  thf_mode_e wmode, rmode;
  logic      ld_mode_w, ld_mode_r;
  logic      wr_req, off_wr, rd_both, ld_r, rd_req, off_rd;
  logic      we, re;
  logic [AW:0]   wbin, wgray, rbin, rgray, wgray_s, rgray_s;
  logic [AW-1:0] empty_off, full_off;
  logic [DW-1:0] off_word;
  logic [DW-1:0] mem [DEPTH];

  // mode is captured in each domain while reset is held
  always_ff @(posedge wclk) if (!rst_n) wmode <= wen2_ld ? MODE_TWO_EN : MODE_LOAD;
  always_ff @(posedge rclk) if (!rst_n) rmode <= wen2_ld ? MODE_TWO_EN : MODE_LOAD;

  assign ld_mode_w = (wmode == MODE_LOAD);
  assign ld_mode_r = (rmode == MODE_LOAD);
  assign wr_req    = !wen1_n && wen2_ld;
  assign off_wr    = ld_mode_w && !wen2_ld && !wen1_n;
  assign rd_both   = !ren1_n && !ren2_n;
  assign ld_r      = ld_mode_r && !wen2_ld;
  assign off_rd    = ld_r && rd_both;
  assign rd_req    = rd_both && !ld_r;

  thf_sync2 #(.W(AW + 1)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
  thf_sync2 #(.W(AW + 1)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

  thf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rgray_s(rgray_s),
    .full_off(full_off), .we(we), .wbin(wbin), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n)
  );

  thf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wgray_s(wgray_s),
    .empty_off(empty_off), .re(re), .rbin(rbin), .rgray(rgray),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  thf_offsets #(.DW(DW), .AW(AW), .DEF_OFF(DEF_OFF)) u_off (
    .rst_n(rst_n), .wclk(wclk), .off_wr(off_wr), .din(din),
    .rclk(rclk), .off_rd(off_rd), .empty_off(empty_off),
    .full_off(full_off), .rd_word(off_word)
  );

  always_ff @(posedge wclk) if (we) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      dout <= '0;
    else if (re)     dout <= mem[rbin[AW-1:0]];
    else if (off_rd) dout <= off_word;
  end
endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk #(
  parameter int DW = 9,
  parameter int AW = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          wen2_ld,
  input logic          ren1_n,
  input logic          ren2_n,
  input logic [DW-1:0] dout,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wgray,
  input logic          ld_mode_w
);
  logic rst_seen_w, rst_seen_r;
  always_ff @(posedge wclk) rst_seen_w <= !rst_n;
  always_ff @(posedge rclk) rst_seen_r <= !rst_n;

  always @(negedge wclk) begin
    if (!rst_n && rst_seen_w === 1'b1) begin
      // R1
      reset_wflags_chk: assert (full_n && afull_n);
    end
  end

  always @(negedge rclk) begin
    if (!rst_n && rst_seen_r === 1'b1) begin
      // R1
      reset_rflags_chk: assert (!empty_n && !aempty_n && dout == '0);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));

  // R7
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));

  // R4
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren1_n || ren2_n) |=> $stable(dout));

  // R2
  dual_gate_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!ld_mode_w && !wen2_ld) |=> $stable(wbin));

  // R9
  load_no_push_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_mode_w && !wen2_ld) |=> $stable(wbin));

  // R11
  gray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
endmodule

bind thr_fifo thr_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .aempty_n(aempty_n), .wen2_ld(wen2_ld), .ren1_n(ren1_n),
  .ren2_n(ren2_n), .dout(dout), .wbin(wbin), .rbin(rbin), .wgray(wgray),
  .ld_mode_w(ld_mode_w)
);

// File: tb/thr_fifo_tb.sv
module thr_fifo_tb;
  localparam int DW = 9;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic full_n, afull_n, empty_n, aempty_n;
  logic [DW-1:0] dout;

  thr_fifo #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(7)) u_dut (
    .rst_n(rst_n), .wclk(clk), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
    .full_n(full_n), .afull_n(afull_n), .rclk(clk), .ren1_n(ren1_n),
    .ren2_n(ren2_n), .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] last_q = '0;
  int  e_off = 7, f_off = 7;
  bit  load_mode = 0, wsel = 0, rsel = 0;
  bit  done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit w1, input bit w2, input bit r1, input bit r2, input logic [DW-1:0] d);
    bit fs, es;
    logic [DW-1:0] e;
    wen1_n = w1; wen2_ld = w2; ren1_n = r1; ren2_n = r2; din = d;
    fs = full_n; es = empty_n;
    @(posedge clk);
    @(negedge clk);
    if (load_mode && !w2 && !r1 && !r2) begin
      e = rsel ? DW'(f_off) : DW'(e_off);
      rsel = ~rsel;
      chk("R10", dout, e);
      last_q = e;
    end else if (!r1 && !r2 && es) begin
      e = mq.pop_front();
      chk("R5", dout, e);
      last_q = e;
    end else begin
      chk((!r1 && !r2) ? "R7" : "R4", dout, last_q);
    end
    if (!w1 && w2 && fs) mq.push_back(d);
    if (load_mode && !w1 && !w2) begin
      if (wsel) f_off = int'(d); else e_off = int'(d);
      wsel = ~wsel;
    end
    wen1_n = 1'b1; wen2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic settle(input string tag);
    int sz;
    repeat (6) cyc(1, 1, 1, 1, '0);
    sz = mq.size();
    chk(tag, {full_n, afull_n, empty_n, aempty_n},
        {28'd0, sz < DEPTH, sz < DEPTH - f_off, sz != 0, sz > e_off});
  endtask

  task automatic do_reset(input bit w2);
    @(negedge clk);
    rst_n = 1'b0; wen2_ld = w2; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {full_n, afull_n, empty_n, aempty_n}, 32'b1100);
    chk("R1", dout, 0);
    rst_n = 1'b1; wen2_ld = 1'b1;
    mq.delete(); last_q = '0; e_off = 7; f_off = 7; wsel = 0; rsel = 0;
    load_mode = !w2;
    @(negedge clk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, DW'($urandom));
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, '0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    // dual-enable mode
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, DW'(i + 5)); // R2: enable two low
    settle("R2");
    write_n(3);
    settle("R2");
    read_n(3);
    settle("R5");
    // R8 default thresholds and R6 capacity
    write_n(7);      settle("R8");
    write_n(1);      settle("R8");
    write_n(DEPTH - 8 - 8); settle("R8");
    write_n(1);      settle("R8");
    write_n(7);      settle("R6");
    chk("R6", full_n, 0);
    write_n(4);      // dropped while full
    chk("R6", mq.size(), DEPTH);
    read_n(DEPTH);
    read_n(3);       // R7 reads on empty
    settle("R7");
    // random mixed traffic
    for (int k = 0; k < 4000; k++) begin
      cyc(bit'($urandom % 2), ($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0, DW'($urandom));
      if (k % 500 == 499) settle("R11");
    end
    read_n(DEPTH);
    settle("R11");

    // load mode
    do_reset(1'b0);
    cyc(0, 0, 1, 1, 9'd3);   // R9 empty offset
    cyc(0, 0, 1, 1, 9'd10);  // R9 full offset
    settle("R9");
    cyc(1, 0, 0, 0, '0);     // R10 readback
    cyc(1, 0, 0, 0, '0);
    write_n(3);  settle("R3");
    write_n(1);  settle("R3");
    cyc(1, 0, 0, 0, '0);     // R10 no pop
    settle("R10");
    write_n(DEPTH - 10 - 1 - 4); settle("R8");
    write_n(1);  settle("R8");
    read_n(DEPTH - 10 - 3);  settle("R8");
    read_n(1);   settle("R8");
    for (int k = 0; k < 3000; k++) begin
      cyc(bit'($urandom % 2), ($urandom % 8) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0, DW'($urandom));
      if (k % 500 == 499) settle("R11");
    end
    read_n(DEPTH);
    settle("R11");
    report();
  end
endmodule